// File: doc/BRIEF.md
# Binarized Neuron Datapath with Ping-Pong Activation Buffers

This block evaluates a binarized fully connected layer one neuron at a time. On each weight step the sequencer presents one weight bit. The block picks the matching activation bit from the buffer currently being read and multiplies the two with an XNOR. A saturating up/down accumulator counts the result up by one on a match and down by one on a mismatch. When the last weight of a neuron has been applied, the sign of the sum becomes that neuron's one-bit output. The output is 1 when the sum is zero or above.

The output bits are collected eight at a time, one shift register per buffer, and then written as a byte into the buffer that is not being read. Two external byte-wide buffers take turns. In even layers buffer A is read and buffer B is written. In odd layers the roles swap, so each layer's result becomes the next layer's input without any copying. The read data ports are combinational: a buffer returns the byte at its current address in the same cycle.

The sequencer only raises a step strobe and supplies two sizes: weights per neuron and neurons per layer. The neuron count must be a multiple of eight. The cycle after each neuron's last step is a settle cycle, in which the step strobe is ignored.

Top module: `bnn_neuron_pingpong`

## Requirements
- R1: After reset no write enable is high, both address outputs are 0, and layer 0 reads buffer A.
- R2: Each accepted step adds +1 to the sum when weight_bit equals the selected activation bit and -1 otherwise. The neuron output bit is 1 when the final sum is >= 0 (a sum of exactly 0 gives 1, a sum of -2 gives 0).
- R3: The sum saturates at +511 and -512 instead of wrapping. 600 matching steps give output 1, and 600 mismatching steps give output 0.
- R4: When bit 0 of the layer count is 0, activations come from rd_data_a and results go to buffer B (we_b). When it is 1, activations come from rd_data_b and results go to buffer A (we_a). Buffer A is never written while it is being read, and the same holds for buffer B.
- R5: For weight index k within a neuron, the read buffer's address output equals k >> 3, and the activation used is bit (k mod 8) of that buffer's read data.
- R6: The output of neuron n is placed at bit (n mod 8) of the byte written at address n >> 3. The byte is written once neurons n-7 to n are complete, with n mod 8 = 7.
- R7: A byte write is a single-cycle pulse in the cycle right after the step that completes the eighth neuron. we_a and we_b are never high together, and the write address equals the node count's byte index from the previous cycle.
- R8: In the cycle after a neuron's last step, step is ignored, and the next neuron's sum starts from 0.
- R9: A neuron completes after fan_in accepted steps. A layer completes after layer_nodes neurons. The weight and node counts then restart at 0 and the layer count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Apply one weight this cycle |
| weight_bit | input | 1 | Weight bit for this step |
| fan_in | input | 10 | Weights per neuron (nonzero) |
| layer_nodes | input | 10 | Neurons per layer (multiple of 8) |
| rd_data_a | input | 8 | Read data from buffer A |
| rd_data_b | input | 8 | Read data from buffer B |
| addr_a | output | 7 | Address to buffer A (read or write) |
| addr_b | output | 7 | Address to buffer B (read or write) |
| wdata_a | output | 8 | Write data for buffer A |
| wdata_b | output | 8 | Write data for buffer B |
| we_a | output | 1 | Write enable for buffer A |
| we_b | output | 1 | Write enable for buffer B |

## Verification
Several properties are checked on every cycle: the write enables are mutually exclusive single-cycle pulses, each pulse follows a completed neuron, the write address is the previous cycle's node byte index, and the accumulator never jumps between its two limits. The bench's scenarios show the rest. These are the XNOR arithmetic and the sign at sums of 0, -2 and +4; saturation against a wrap, which would flip the answer for 600 equal terms; the swap of buffer roles across three layers, so that results read back as the next layer's input; the bit order inside packed bytes; and the ignored step in the settle cycle.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
   typedef enum logic {
      BUF_A = 1'b0,
      BUF_B = 1'b1
   } buf_id_e;

   localparam int unsigned NUM_BUFS = 2;
endpackage

// File: rtl/bnn_seq.sv
module bnn_seq #(
   parameter int unsigned CNT_W   = 10,
   parameter int unsigned LAYER_W = 2,
   parameter int unsigned SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] fan_in,
   input  logic [CNT_W-1:0] layer_nodes,
   output logic             step_eff,
   output logic             node_done,
   output logic             settle,
   output logic             flush,
   output logic             rd_sel,
   output logic [CNT_W-1:0] wcnt,
   output logic [CNT_W-1:0] ncnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0]   wcnt_q;
   logic [CNT_W-1:0]   ncnt_q;
   logic [CNT_W-1:0]   ncnt_nx;
   logic [LAYER_W-1:0] layer_q;
   logic               settle_q;
   logic               flush_q;
   logic               layer_done;

   assign step_eff   = step & ~settle_q;
   assign node_done  = step_eff && (wcnt_q == fan_in - ONE);
   assign layer_done = node_done && (ncnt_q == layer_nodes - ONE);
   assign ncnt_nx    = layer_done ? '0 : ncnt_q + ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt_q   <= '0;
         ncnt_q   <= '0;
         layer_q  <= '0;
         settle_q <= 1'b0;
         flush_q  <= 1'b0;
      end else begin
         settle_q <= node_done;
         flush_q  <= node_done && (ncnt_nx[SEL_W-1:0] == '0);
         if (step_eff) begin
            if (node_done) wcnt_q <= '0;
            else           wcnt_q <= wcnt_q + ONE;
         end
         if (node_done)  ncnt_q  <= ncnt_nx;
         if (layer_done) layer_q <= layer_q + LAYER_W'(1);
      end
   end

   assign settle = settle_q;
   assign flush  = flush_q;
   assign rd_sel = layer_q[0];
   assign wcnt   = wcnt_q;
   assign ncnt   = ncnt_q;
endmodule

// File: rtl/bnn_mac.sv
module bnn_mac #(
   parameter int unsigned ACC_W    = 10,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_eff,
   input  logic             clear,
   input  logic             weight_bit,
   input  logic             act_bit,
   output logic             sign_bit,
   output logic [ACC_W-1:0] acc
);
   localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
   localparam logic [ACC_W-1:0] ONE     = ACC_W'(1);

   logic             match;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_step;
   logic [ACC_W-1:0] acc_nx;

   assign match = ~(weight_bit ^ act_bit);

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (match) acc_step = (acc_q == ACC_MAX) ? acc_q : acc_q + ONE;
            else       acc_step = (acc_q == ACC_MIN) ? acc_q : acc_q - ONE;
         end
      end else begin : g_wrap
         assign acc_step = match ? acc_q + ONE : acc_q - ONE;
      end
   endgenerate

   assign acc_nx   = step_eff ? acc_step : acc_q;
   assign sign_bit = ~acc_nx[ACC_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else            acc_q <= acc_nx;
   end

   assign acc = acc_q;
endmodule

// File: rtl/bnn_packer.sv
module bnn_packer #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [BYTE_W-1:0] wdata
);
   logic [BYTE_W-1:0] sreg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        sreg_q <= '0;
      else if (shift_en) sreg_q <= {sreg_q[BYTE_W-2:0], bit_in};
   end

   // oldest bit sits at the top of the register; flip so it lands in bit 0
   for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
      assign wdata[i] = sreg_q[BYTE_W-1-i];
   end
endmodule

// File: rtl/bnn_port_sel.sv
module bnn_port_sel #(
   parameter int unsigned ADDR_W = 7,
   parameter bit          BUF_ID = 1'b0
) (
   input  logic              rd_sel_d,
   input  logic              flush,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] addr,
   output logic              we
);
   logic reading;

   assign reading = (rd_sel_d == BUF_ID);
   assign addr    = reading ? rd_addr : wr_addr;
   assign we      = flush & ~reading;
endmodule

// File: rtl/bnn_neuron_pingpong.sv
module bnn_neuron_pingpong #(
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned ACC_W    = 10,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned LAYER_W  = 2,
   parameter bit          SATURATE = 1'b1,
   localparam int unsigned SEL_W   = $clog2(BYTE_W),
   localparam int unsigned ADDR_W  = CNT_W - SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              weight_bit,
   input  logic [CNT_W-1:0]  fan_in,
   input  logic [CNT_W-1:0]  layer_nodes,
   input  logic [BYTE_W-1:0] rd_data_a,
   input  logic [BYTE_W-1:0] rd_data_b,
   output logic [ADDR_W-1:0] addr_a,
   output logic [ADDR_W-1:0] addr_b,
   output logic [BYTE_W-1:0] wdata_a,
   output logic [BYTE_W-1:0] wdata_b,
   output logic              we_a,
   output logic              we_b
);
   import bnn_pkg::*;

   generate
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte
         $error("BYTE_W must be a power of two, at least 2");
      end
      if (CNT_W <= SEL_W) begin : g_bad_cnt
         $error("CNT_W must exceed log2(BYTE_W)");
      end
      if (ACC_W < 2) begin : g_bad_acc
         $error("ACC_W must be at least 2");
      end
      if (LAYER_W < 1) begin : g_bad_layer
         $error("LAYER_W must be at least 1");
      end
   endgenerate

   logic              step_eff;
   logic              node_done;
   logic              settle;
   logic              flush;
   logic              rd_sel;
   logic              rd_sel_d;
   logic [CNT_W-1:0]  wcnt;
   logic [CNT_W-1:0]  ncnt;
   logic [ADDR_W-1:0] rd_addr;
   logic [ADDR_W-1:0] wr_addr_q;
   logic [BYTE_W-1:0] rd_byte;
   logic              act_bit;
   logic              sign_bit;
   logic [ACC_W-1:0]  acc_val;

   bnn_seq #(.CNT_W(CNT_W), .LAYER_W(LAYER_W), .SEL_W(SEL_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step),
      .fan_in      (fan_in),
      .layer_nodes (layer_nodes),
      .step_eff    (step_eff),
      .node_done   (node_done),
      .settle      (settle),
      .flush       (flush),
      .rd_sel      (rd_sel),
      .wcnt        (wcnt),
      .ncnt        (ncnt)
   );

   assign rd_byte = (rd_sel == BUF_B) ? rd_data_b : rd_data_a;
   assign act_bit = rd_byte[wcnt[SEL_W-1:0]];
   assign rd_addr = wcnt[CNT_W-1:SEL_W];

   bnn_mac #(.ACC_W(ACC_W), .SATURATE(SATURATE)) u_mac (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_eff   (step_eff),
      .clear      (settle),
      .weight_bit (weight_bit),
      .act_bit    (act_bit),
      .sign_bit   (sign_bit),
      .acc        (acc_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_sel_d  <= 1'b0;
         wr_addr_q <= '0;
      end else begin
         rd_sel_d  <= rd_sel;
         wr_addr_q <= ncnt[CNT_W-1:SEL_W];
      end
   end

   logic [ADDR_W-1:0] addr_v  [NUM_BUFS];
   logic [BYTE_W-1:0] wdata_v [NUM_BUFS];
   logic              we_v    [NUM_BUFS];

   for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
      bnn_packer #(.BYTE_W(BYTE_W)) u_pack (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (node_done && (rd_sel != 1'(b))),
         .bit_in   (sign_bit),
         .wdata    (wdata_v[b])
      );
      bnn_port_sel #(.ADDR_W(ADDR_W), .BUF_ID(1'(b))) u_sel (
         .rd_sel_d (rd_sel_d),
         .flush    (flush),
         .rd_addr  (rd_addr),
         .wr_addr  (wr_addr_q),
         .addr     (addr_v[b]),
         .we       (we_v[b])
      );
   end

   assign addr_a  = addr_v[0];
   assign addr_b  = addr_v[1];
   assign wdata_a = wdata_v[0];
   assign wdata_b = wdata_v[1];
   assign we_a    = we_v[0];
   assign we_b    = we_v[1];
endmodule

// File: rtl/bnn_neuron_pingpong_chk.sv
module bnn_neuron_pingpong_chk #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned ACC_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we_a,
   input logic              we_b,
   input logic              node_done,
   input logic [ADDR_W-1:0] addr_a,
   input logic [ADDR_W-1:0] addr_b,
   input logic [ADDR_W-1:0] node_byte,
   input logic [ACC_W-1:0]  acc
);
   localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   // R7
   we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_a && we_b));

   // R7
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_a || we_b) |=> !(we_a || we_b));

   // R7
   we_after_node_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_a || we_b) |-> $past(node_done));

   // R6
   wr_addr_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_a |-> (addr_a == $past(node_byte)));

   // R6
   wr_addr_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_b |-> (addr_b == $past(node_byte)));

   // R3
   no_wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_MAX) |=> (acc != ACC_MIN));

   // R3
   no_wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_MIN) |=> (acc != ACC_MAX));
endmodule

bind bnn_neuron_pingpong bnn_neuron_pingpong_chk #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .we_a      (we_a),
   .we_b      (we_b),
   .node_done (node_done),
   .addr_a    (addr_a),
   .addr_b    (addr_b),
   .node_byte (ncnt[CNT_W-1:SEL_W]),
   .acc       (acc_val)
);

// File: tb/bnn_neuron_pingpong_test.sv
module bnn_neuron_pingpong_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step = 1'b0;
   logic       weight_bit = 1'b0;
   logic [9:0] fan_in = 10'd16;
   logic [9:0] layer_nodes = 10'd8;
   logic [7:0] rd_data_a, rd_data_b;
   logic [6:0] addr_a, addr_b;
   logic [7:0] wdata_a, wdata_b;
   logic       we_a, we_b;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [7:0] mem_a [128];
   logic [7:0] mem_b [128];
   logic [7:0] ex_a  [128];
   logic [7:0] ex_b  [128];

   typedef struct {
      bit       buf_b;
      bit [6:0] addr;
      bit [7:0] data;
   } wr_item_t;
   wr_item_t sb [$];

   always #2.5 clk = ~clk;

   bnn_neuron_pingpong uut (
      .clk(clk), .rst_n(rst_n), .step(step), .weight_bit(weight_bit),
      .fan_in(fan_in), .layer_nodes(layer_nodes),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
      .addr_a(addr_a), .addr_b(addr_b), .wdata_a(wdata_a), .wdata_b(wdata_b),
      .we_a(we_a), .we_b(we_b)
   );

   assign rd_data_a = mem_a[addr_a];
   assign rd_data_b = mem_b[addr_b];

   always @(posedge clk) begin
      if (we_a) mem_a[addr_a] <= wdata_a;
      if (we_b) mem_b[addr_b] <= wdata_b;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_test();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // monitor: sample one time unit after the rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && (we_a || we_b)) begin
            if (sb.size() == 0) begin
               check(1'b0, "R7 unexpected write", {we_b, we_a}, 0);
            end else begin
               wr_item_t it;
               it = sb.pop_front();
               check((it.buf_b ? we_b : we_a) && !(it.buf_b ? we_a : we_b),
                     "R4 write target", {we_b, we_a}, it.buf_b ? 2 : 1);
               check((it.buf_b ? addr_b : addr_a) == it.addr,
                     "R6 write address", it.buf_b ? addr_b : addr_a, it.addr);
               check((it.buf_b ? wdata_b : wdata_a) == it.data,
                     "R2 R3 R6 write data", it.buf_b ? wdata_b : wdata_a, it.data);
            end
         end
      end
   end

   function automatic bit wfun(int l, int n, int k, bit act);
      if (l == 2 && n == 0) return act;
      if (l == 2 && n == 1) return ~act;
      if (l == 2 && n == 2) return (k < 300) ? act : ~act;
      if (l == 2 && n == 3) return (k < 299) ? act : ~act;
      if (l == 2 && n == 4) return (k < 302) ? act : ~act;
      return ((k * 5 + n * 3 + l) % 7) < 3;
   endfunction

   task automatic run_layer(input int l, input int fin, input int nn, input bit poke_settle);
      bit       rsel;
      bit [7:0] pack;
      rsel = l[0];
      @(negedge clk);
      fan_in = 10'(fin);
      layer_nodes = 10'(nn);
      pack = '0;
      for (int n = 0; n < nn; n++) begin
         int sum;
         sum = 0;
         for (int k = 0; k < fin; k++) begin
            bit act, w;
            @(negedge clk);
            act = rsel ? ex_b[k >> 3][k % 8] : ex_a[k >> 3][k % 8];
            w = wfun(l, n, k, act);
            step = 1'b1;
            weight_bit = w;
            if (w == act) sum = (sum < 511) ? sum + 1 : 511;
            else          sum = (sum > -512) ? sum - 1 : -512;
            #1;
            if (k % 8 == 0 || k == fin - 1)
               check((rsel ? addr_b : addr_a) == 7'(k >> 3), "R5 R4 read address",
                     rsel ? addr_b : addr_a, k >> 3);
         end
         pack[n % 8] = (sum >= 0);
         if (n % 8 == 7) begin
            wr_item_t it;
            it.buf_b = ~rsel;
            it.addr  = 7'(n >> 3);
            it.data  = pack;
            sb.push_back(it);
            if (rsel) ex_a[n >> 3] = pack;
            else      ex_b[n >> 3] = pack;
         end
         // settle cycle: R8 step here must have no effect
         @(negedge clk);
         step = poke_settle;
         weight_bit = n[0];
      end
      @(negedge clk);
      step = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_test();
   end

   initial begin
      for (int i = 0; i < 128; i++) begin
         mem_a[i] = 8'(i * 37 + 5);
         ex_a[i]  = 8'(i * 37 + 5);
         mem_b[i] = 8'hA5;
         ex_b[i]  = 8'hA5;
      end
      repeat (4) @(negedge clk);
      // R1: reset state
      check(!we_a, "R1 we_a", we_a, 0);
      check(!we_b, "R1 we_b", we_b, 0);
      check(addr_a == 0, "R1 addr_a", addr_a, 0);
      check(addr_b == 0, "R1 addr_b", addr_b, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!we_a && !we_b, "R1 idle after reset", {we_b, we_a}, 0);

      // layer 0: read A write B, 16 neurons of 20 weights, settle steps poked (R8, R9)
      run_layer(0, 20, 16, 1'b1);
      // layer 1: read B write A (R4)
      run_layer(1, 16, 8, 1'b0);
      // layer 2: read A again, saturation and sign corners (R2, R3)
      run_layer(2, 600, 8, 1'b1);
      // layer 3: read B written by layer 2
      run_layer(3, 8, 8, 1'b0);

      check(sb.size() == 0, "R7 all writes seen", sb.size(), 0);
      check(mem_a[0] == ex_a[0] && mem_b[0] == ex_b[0], "R4 buffer contents",
            {mem_a[0], mem_b[0]}, {ex_a[0], ex_b[0]});
      finish_test();
   end
endmodule